// File: doc/BRIEF.md
# Adaptive Code-Strength Selector

This block decides how much Reed-Solomon redundancy the transmitter adds to the packets it sends next. It watches the acknowledgement outcome that the link already reports for every packet. It counts packets over a window of programmable length and counts how many of them came back unacknowledged. When a window closes, it compares that error count with an upper and a lower threshold. A loss rate above the upper threshold moves it one step to a stronger code with more parity. A rate below the lower threshold moves it one step to a weaker code with a higher rate. No separate feedback path is needed.

The selector is a four-state machine. The states are `ST_T2`, `ST_T4`, `ST_T8` and `ST_T16`, and each one stands for a code that corrects t = 2, 4, 8 or 16 symbol errors. On every clock the machine takes one of three transitions: **STRENGTHEN** moves to the next stronger state, **RELAX** moves to the next weaker state, and **HOLD** stays put. STRENGTHEN and RELAX happen only at a window end. A transition that would go past `ST_T16` or below `ST_T2` becomes HOLD. The state the machine is in is the *pending* choice. It reaches the outputs only at a transmit packet boundary, so a packet is never encoded with two different code strengths. The outputs are the code index and its parity count, n−k = 2t.

Top module: `fec_strength_sel`

## Requirements
- R1: After reset the outputs show code index 0 with parity 4, and the settings are window length 16, upper threshold 4 and lower threshold 1.
- R2: The parity output always equals 2t for the displayed index: 0→4, 1→8, 2→16, 3→32.
- R3: A window closes on the completed packet that brings the packet count up to the window length. The error count of that window, including the closing packet, is the value compared with the thresholds. Both counters then restart from zero, so no errors carry over into the next window.
- R4: When a window's error count is strictly greater than the upper threshold, the pending choice moves one step stronger.
- R5: When a window's error count is strictly less than the lower threshold, the pending choice moves one step weaker.
- R6: When a window's error count is equal to either threshold or lies between them, the pending choice is held.
- R7: A strengthen at index 3 and a relax at index 0 leave the index unchanged.
- R8: The pending choice moves by at most one step per window, however many errors the window holds.
- R9: The code index and parity outputs change only on the clock after `tx_sof` is high. At that edge they load the pending choice.
- R10: A configuration write with `cfg_we` high stores `cfg_wdata` at `cfg_addr`. Address 0 holds the window length, 1 the upper threshold and 2 the lower threshold. A write to address 3 changes nothing. A window length of 0 acts as a length of 1.
- R11: Only cycles with `ack_valid` high count as packets. `ack_ok`=1 means the packet was acknowledged and 0 means it was lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CNT_W | Configuration write data |
| ack_valid | input | 1 | One packet's delivery outcome is present |
| ack_ok | input | 1 | 1 = acknowledged, 0 = lost |
| tx_sof | input | 1 | Transmit packet boundary; applies the pending choice |
| code_idx | output | 2 | Active code strength index (t = 2 << index) |
| parity_cnt | output | PAR_W | Parity symbols n−k of the active code |

## Verification
The hardest situation to reach from the ports is a pending choice that differs from the active one. The state machine can only be seen through the packet-boundary latch. Each scenario therefore closes a window and samples the outputs before any `tx_sof`, to show they have not moved. It then pulses `tx_sof` and samples again. Carry-over between windows is exposed by two back-to-back windows whose error counts lie inside the thresholds on their own but would exceed the upper threshold if added together.

// File: rtl/fec_sel_pkg.sv
package fec_sel_pkg;

    typedef enum logic [1:0] {
        ST_T2  = 2'd0,
        ST_T4  = 2'd1,
        ST_T8  = 2'd2,
        ST_T16 = 2'd3
    } strength_e;

    typedef enum logic [1:0] {
        V_HOLD       = 2'd0,
        V_STRENGTHEN = 2'd1,
        V_RELAX      = 2'd2
    } verdict_e;

    localparam logic [1:0] CFG_WIN_LEN = 2'd0;
    localparam logic [1:0] CFG_THR_HI  = 2'd1;
    localparam logic [1:0] CFG_THR_LO  = 2'd2;

endpackage

// File: rtl/fec_sel_cfg.sv
module fec_sel_cfg
    import fec_sel_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int WIN_DEF = 16,
    parameter int HI_DEF  = 4,
    parameter int LO_DEF  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] win_len,
    output logic [CNT_W-1:0] thr_hi,
    output logic [CNT_W-1:0] thr_lo
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_len <= CNT_W'(WIN_DEF);
            thr_hi  <= CNT_W'(HI_DEF);
            thr_lo  <= CNT_W'(LO_DEF);
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_WIN_LEN: win_len <= cfg_wdata;
                CFG_THR_HI:  thr_hi  <= cfg_wdata;
                CFG_THR_LO:  thr_lo  <= cfg_wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fec_sel_window.sv
module fec_sel_window
    import fec_sel_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_valid,
    input  logic             ack_ok,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] thr_hi,
    input  logic [CNT_W-1:0] thr_lo,
    output logic             win_end,
    output verdict_e         verdict,
    output logic [CNT_W-1:0] win_cnt
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] err_cnt;
    logic [EXT_W-1:0] cnt_next;
    logic [EXT_W-1:0] err_next;
    logic [EXT_W-1:0] len_eff;

    always_comb begin
        len_eff  = (win_len == '0) ? EXT_W'(1) : EXT_W'(win_len);
        cnt_next = EXT_W'(win_cnt) + EXT_W'(1);
        err_next = EXT_W'(err_cnt) + EXT_W'(!ack_ok);
        win_end  = ack_valid && (cnt_next >= len_eff);
        if (err_next > EXT_W'(thr_hi))
            verdict = V_STRENGTHEN;
        else if (err_next < EXT_W'(thr_lo))
            verdict = V_RELAX;
        else
            verdict = V_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            err_cnt <= '0;
        end else if (win_end) begin
            win_cnt <= '0;
            err_cnt <= '0;
        end else if (ack_valid) begin
            win_cnt <= cnt_next[CNT_W-1:0];
            err_cnt <= err_next[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/fec_sel_fsm.sv
module fec_sel_fsm
    import fec_sel_pkg::*;
#(
    parameter int T_MIN = 2,
    parameter int PAR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end,
    input  verdict_e         verdict,
    input  logic             tx_sof,
    output logic [1:0]       pend_idx,
    output logic [1:0]       code_idx,
    output logic [PAR_W-1:0] parity_cnt
);

    localparam int NUM_ST = 4;

    strength_e        state_q;
    strength_e        state_d;
    logic [PAR_W-1:0] par_lut [NUM_ST];

    for (genvar g = 0; g < NUM_ST; g++) begin : g_par_lut
        assign par_lut[g] = PAR_W'(2 * T_MIN) << g;
    end

    logic step_up;
    logic step_dn;
    assign step_up = win_end && (verdict == V_STRENGTHEN);
    assign step_dn = win_end && (verdict == V_RELAX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_T2: begin
                if (step_up) state_d = ST_T4;
            end
            ST_T4: begin
                if (step_up)      state_d = ST_T8;
                else if (step_dn) state_d = ST_T2;
            end
            ST_T8: begin
                if (step_up)      state_d = ST_T16;
                else if (step_dn) state_d = ST_T4;
            end
            ST_T16: begin
                if (step_dn) state_d = ST_T8;
            end
            default: state_d = ST_T2;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_T2;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_idx   <= 2'd0;
            parity_cnt <= par_lut[0];
        end else if (tx_sof) begin
            code_idx   <= state_q;
            parity_cnt <= par_lut[state_q];
        end
    end

    assign pend_idx = state_q;

endmodule

// File: rtl/fec_strength_sel.sv
module fec_strength_sel
    import fec_sel_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PAR_W   = 8,
    parameter int T_MIN   = 2,
    parameter int WIN_DEF = 16,
    parameter int HI_DEF  = 4,
    parameter int LO_DEF  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             ack_valid,
    input  logic             ack_ok,
    input  logic             tx_sof,
    output logic [1:0]       code_idx,
    output logic [PAR_W-1:0] parity_cnt
);

    logic [CNT_W-1:0] win_len;
    logic [CNT_W-1:0] thr_hi;
    logic [CNT_W-1:0] thr_lo;
    logic             win_end;
    verdict_e         verdict;
    logic [CNT_W-1:0] win_cnt;
    logic [1:0]       pend_idx;

    fec_sel_cfg #(
        .CNT_W(CNT_W), .WIN_DEF(WIN_DEF), .HI_DEF(HI_DEF), .LO_DEF(LO_DEF)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .win_len(win_len), .thr_hi(thr_hi), .thr_lo(thr_lo)
    );

    fec_sel_window #(.CNT_W(CNT_W)) u_window (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ok(ack_ok),
        .win_len(win_len), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .win_end(win_end), .verdict(verdict), .win_cnt(win_cnt)
    );

    fec_sel_fsm #(.T_MIN(T_MIN), .PAR_W(PAR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .win_end(win_end), .verdict(verdict),
        .tx_sof(tx_sof), .pend_idx(pend_idx), .code_idx(code_idx),
        .parity_cnt(parity_cnt)
    );

endmodule

// File: rtl/fec_strength_sel_chk.sv
module fec_strength_sel_chk #(
    parameter int CNT_W = 8,
    parameter int PAR_W = 8,
    parameter int T_MIN = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_sof,
    input logic [1:0]       code_idx,
    input logic [PAR_W-1:0] parity_cnt,
    input logic [1:0]       pend_idx,
    input logic             win_end,
    input logic [CNT_W-1:0] win_cnt
);

    p_parity_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        parity_cnt == (PAR_W'(2 * T_MIN) << code_idx));

    p_out_at_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sof |=> $stable(code_idx) && $stable(parity_cnt));

    p_hold_between_windows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(pend_idx));

    p_clear_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> win_cnt == '0);

    p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (pend_idx == $past(pend_idx)) ||
                    (pend_idx == $past(pend_idx) + 2'd1) ||
                    (pend_idx + 2'd1 == $past(pend_idx)));

    p_top_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pend_idx) == 2'd3 |-> pend_idx != 2'd0);

endmodule

bind fec_strength_sel fec_strength_sel_chk #(
    .CNT_W(CNT_W), .PAR_W(PAR_W), .T_MIN(T_MIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_sof(tx_sof), .code_idx(code_idx),
    .parity_cnt(parity_cnt), .pend_idx(pend_idx), .win_end(win_end),
    .win_cnt(win_cnt)
);

// File: tb/fec_strength_sel_bench.sv
module fec_strength_sel_bench;

    localparam int CNT_W = 8;
    localparam int PAR_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = 2'd0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic             ack_valid = 1'b0;
    logic             ack_ok = 1'b1;
    logic             tx_sof = 1'b0;
    logic [1:0]       code_idx;
    logic [PAR_W-1:0] parity_cnt;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    fec_strength_sel u_fec_strength_sel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ack_valid(ack_valid), .ack_ok(ack_ok),
        .tx_sof(tx_sof), .code_idx(code_idx), .parity_cnt(parity_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int idx);
        chk({req, " index"}, int'(code_idx), idx);
        chk({req, " parity"}, int'(parity_cnt), 4 << idx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [1:0] a, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CNT_W'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // n packets, the first nerr lost; gap idle cycles after each
    task automatic send_pkts(input int n, input int nerr, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ack_valid = 1'b1; ack_ok = (i >= nerr);
            @(negedge clk);
            ack_valid = 1'b0; ack_ok = 1'b1;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic pulse_sof();
        @(negedge clk);
        tx_sof = 1'b1;
        @(negedge clk);
        tx_sof = 1'b0;
    endtask

    task automatic t_reset_defaults();
        do_reset();
        chk_out("R1 reset", 0);
        // default window 16, upper 4: 15 packets with 5 losses do not close it
        send_pkts(15, 5, 0);
        pulse_sof();
        chk_out("R1 default window not closed", 0);
        send_pkts(1, 0, 0);
        pulse_sof();
        chk_out("R3 default window closes at 16", 1);
        do_reset();
        chk_out("R1 after second reset", 0);
    endtask

    task automatic t_config();
        cfg_write(2'd0, 8);
        cfg_write(2'd1, 3);
        cfg_write(2'd2, 1);
        cfg_write(2'd3, 0);   // R10: ignored address
    endtask

    task automatic t_strengthen_pending();
        send_pkts(8, 4, 0);
        repeat (3) @(negedge clk);
        chk_out("R9 pending not yet applied", 0);
        pulse_sof();
        chk_out("R4 R10 strengthen after 4 losses over 3", 1);
    endtask

    task automatic t_single_step();
        send_pkts(8, 8, 0);
        pulse_sof();
        chk_out("R8 single step on full loss", 2);
    endtask

    task automatic t_hold_bounds();
        send_pkts(8, 3, 0);
        pulse_sof();
        chk_out("R6 hold at upper threshold", 2);
        send_pkts(8, 1, 0);
        pulse_sof();
        chk_out("R6 R3 hold at lower threshold without carry", 2);
    endtask

    task automatic t_idle_gaps();
        send_pkts(8, 4, 3);
        pulse_sof();
        chk_out("R11 R2 idle gaps do not count", 3);
    endtask

    task automatic t_clamp_top();
        send_pkts(8, 8, 0);
        pulse_sof();
        chk_out("R7 clamp at strongest", 3);
    endtask

    task automatic t_relax();
        send_pkts(8, 0, 0);
        pulse_sof();
        chk_out("R5 relax to 2", 2);
        send_pkts(8, 0, 0);
        pulse_sof();
        chk_out("R5 relax to 1", 1);
        send_pkts(8, 0, 0);
        pulse_sof();
        chk_out("R5 relax to 0", 0);
        send_pkts(8, 0, 0);
        pulse_sof();
        chk_out("R7 clamp at weakest", 0);
    endtask

    task automatic t_zero_window();
        cfg_write(2'd0, 0);
        cfg_write(2'd1, 0);
        cfg_write(2'd2, 0);
        send_pkts(1, 1, 0);
        pulse_sof();
        chk_out("R10 window length 0 acts as 1", 1);
        send_pkts(1, 0, 0);
        pulse_sof();
        chk_out("R6 zero losses equal to zero lower threshold", 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_defaults();
        t_config();
        t_strengthen_pending();
        t_single_step();
        t_hold_bounds();
        t_idle_gaps();
        t_clamp_top();
        t_relax();
        t_zero_window();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule